// File: doc/BRIEF.md
# Two-Wire Programming Host Sequencer

This block is the host end of a two-wire serial programming link: one clock wire that the host drives and one bidirectional data wire. It divides the system clock down to make the programming clock and turns requests from a valid/ready interface into correctly timed frames. There are two kinds of request. An execute-word command carries a 24-bit instruction word to the target. A register-read command makes the target shift a 16-bit value back, and the block returns that value on a valid-qualified output.

Each frame starts with a command code sent least significant bit first, and the payload follows. The host changes its data output only when the programming clock falls, and it samples the target only when the clock rises. On a read it releases the data wire for the whole return phase. After reset or a session-start pulse, the first execute-word command uses a stretched 9-clock code. A request that is already waiting when a frame ends starts on the very next clock, so the target sees no gap.

Top module: `progHostSeq`

## Requirements
- R1: After reset, and while no frame is running, pgClk is low, pgDataOe is high, pgDataOut is low, reqReady is high and rdValid is low.
- R2: While a frame runs, pgClk has a period of 2*HALF_DIV system cycles. Each bit starts with a low half of HALF_DIV cycles and ends with a high half of HALF_DIV cycles. pgClk stays low while no frame runs.
- R3: pgDataOut changes only at the start of a frame or in the cycle in which pgClk falls. It is stable for as long as pgClk is high.
- R4: An execute-word command (reqIsRead=0) sends the code 0000 and then reqWord bit 0 to bit 23, one bit per clock, for 28 clocks in total.
- R5: The first execute-word command after reset sends 9 zero code bits instead of 4, and then the 24 word bits, for 33 clocks. Every later one uses the 4-bit form.
- R6: A register-read command (reqIsRead=1) sends the code 0001 least significant bit first (the first bit is 1), then 8 idle clocks driven low, then 16 read clocks: 28 clocks in total. pgDataOe is low for exactly the 16 read clocks and changes only while pgClk is low.
- R7: pgDataIn is sampled on each rising pgClk edge of the read clocks, and the first bit becomes rdData bit 0. rdValid is a one-cycle pulse in the cycle after the rising edge of the last read clock, and rdData carries the result.
- R8: If a request is valid in the cycle of a frame's final falling edge, it is accepted there. Its first bit starts at once, so pgClk never stays low for more than HALF_DIV cycles between the two frames.
- R9: reqReady is high only while no frame runs, or in the one cycle of a frame's final falling edge. A request held while the block is busy has no effect until then.
- R10: A startSession pulse re-arms the 9-clock form, so the next execute-word command is 33 clocks long even after earlier ones.
- R11: A register-read command leaves the stretched form armed. An execute-word command after it still takes 33 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSession | input | 1 | Re-arms the stretched first-command form |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqIsRead | input | 1 | 1 = register-read command, 0 = execute-word command |
| reqWord | input | 24 | Instruction word for an execute-word command |
| rdValid | output | 1 | One-cycle pulse: rdData holds a read result |
| rdData | output | 16 | Read result, first received bit in bit 0 |
| pgClk | output | 1 | Programming clock |
| pgDataOut | output | 1 | Data value driven to the data wire |
| pgDataOe | output | 1 | 1 = host drives the data wire, 0 = released |
| pgDataIn | input | 1 | Value seen on the data wire |

## Verification
The assertions watch the pin-level timing rules on every cycle. They check that data holds still while the programming clock is high, that every high half lasts exactly HALF_DIV cycles, that the output enable only switches in a low half, that the read pulse is one cycle wide and falls on a rising edge, and that reqReady with the clock high is always followed by a falling edge. The bit contents of each frame cannot be seen by a property. Only the bench's reference model and its scenarios show these: the 9-clock stretched code and its re-arming by startSession, that a read leaves it armed, that back-to-back commands run with no gap, and that read data is put together least significant bit first.

// File: rtl/progHostPkg.sv
package progHostPkg;
  localparam int CODE_BITS      = 4;
  localparam int LONG_CODE_BITS = 9;
  localparam int WORD_BITS      = 24;
  localparam int IDLE_BITS      = 8;
  localparam int READ_BITS      = 16;

  localparam int SHORT_EXEC_LEN = CODE_BITS + WORD_BITS;
  localparam int LONG_EXEC_LEN  = LONG_CODE_BITS + WORD_BITS;
  localparam int READ_LEN       = CODE_BITS + IDLE_BITS + READ_BITS;
  localparam int READ_START     = CODE_BITS + IDLE_BITS;
  localparam int FRAME_W        = LONG_EXEC_LEN;
  localparam int IDX_W          = $clog2(FRAME_W);

  localparam logic [CODE_BITS-1:0] EXEC_CODE = 4'b0000;
  localparam logic [CODE_BITS-1:0] READ_CODE = 4'b0001;

  typedef enum logic [1:0] {LD_EXEC, LD_EXEC_LONG, LD_READ} loadKindT;

  typedef struct packed {
    logic     load;
    loadKindT kind;
    logic     enable;
    logic     readPhase;
    logic     lastRead;
  } ctrlStrobeT;
endpackage

// File: rtl/progHostCtrl.sv
module progHostCtrl
  import progHostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSession,
  input  logic       reqValid,
  input  logic       reqIsRead,
  input  logic       riseTick,
  input  logic       fallTick,
  output logic       reqReady,
  output ctrlStrobeT strobe
);
  logic             running;
  logic             isRead;
  logic             firstPending;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             endFrame;
  logic             accept;
  loadKindT         kind;

  assign endFrame = running && fallTick && (bitIdx == lastIdx);
  assign reqReady = !running || endFrame;
  assign accept   = reqValid && reqReady;

  always_comb begin
    if (reqIsRead)         kind = LD_READ;
    else if (firstPending) kind = LD_EXEC_LONG;
    else                   kind = LD_EXEC;
  end

  always_comb begin
    strobe.load      = accept;
    strobe.kind      = kind;
    strobe.enable    = running;
    strobe.readPhase = running && isRead && (bitIdx >= IDX_W'(READ_START));
    strobe.lastRead  = (bitIdx == IDX_W'(READ_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      isRead  <= 1'b0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else if (accept) begin
      running <= 1'b1;
      isRead  <= reqIsRead;
      bitIdx  <= '0;
      case (kind)
        LD_EXEC_LONG: lastIdx <= IDX_W'(LONG_EXEC_LEN - 1);
        LD_READ:      lastIdx <= IDX_W'(READ_LEN - 1);
        default:      lastIdx <= IDX_W'(SHORT_EXEC_LEN - 1);
      endcase
    end else if (endFrame) begin
      running <= 1'b0;
    end else if (running && fallTick) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    firstPending <= 1'b1;
    else if (startSession)        firstPending <= 1'b1;
    else if (accept && !reqIsRead) firstPending <= 1'b0;
  end

  logic unusedRise;
  assign unusedRise = riseTick;
endmodule

// File: rtl/progHostDatapath.sv
module progHostDatapath
  import progHostPkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strobe,
  input  logic [WORD_BITS-1:0] reqWord,
  input  logic                 pgDataIn,
  output logic                 riseTick,
  output logic                 fallTick,
  output logic                 pgClk,
  output logic                 pgDataOut,
  output logic                 pgDataOe,
  output logic                 rdValid,
  output logic [READ_BITS-1:0] rdData
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic [DIV_W-1:0]     divCnt;
  logic [FRAME_W-1:0]   txShift;
  logic [FRAME_W-1:0]   frameImage;
  logic [READ_BITS-1:0] rxShift;
  logic                 tick;

  assign tick     = strobe.enable && (divCnt == DIV_W'(HALF_DIV - 1));
  assign riseTick = tick && !pgClk;
  assign fallTick = tick && pgClk;

  always_comb begin
    case (strobe.kind)
      LD_EXEC_LONG: frameImage = FRAME_W'({reqWord, LONG_CODE_BITS'(EXEC_CODE)});
      LD_READ:      frameImage = FRAME_W'(READ_CODE);
      default:      frameImage = FRAME_W'({reqWord, EXEC_CODE});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      pgClk   <= 1'b0;
      txShift <= '0;
    end else if (strobe.load) begin
      divCnt  <= '0;
      pgClk   <= 1'b0;
      txShift <= frameImage;
    end else if (strobe.enable) begin
      if (tick) begin
        divCnt <= '0;
        pgClk  <= !pgClk;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (fallTick) txShift <= txShift >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (riseTick && strobe.readPhase) begin
        rxShift <= {pgDataIn, rxShift[READ_BITS-1:1]};
        if (strobe.lastRead) begin
          rdData  <= {pgDataIn, rxShift[READ_BITS-1:1]};
          rdValid <= 1'b1;
        end
      end
    end
  end

  assign pgDataOut = txShift[0];
  assign pgDataOe  = !strobe.readPhase;
endmodule

// File: rtl/progHostSeq.sv
module progHostSeq
  import progHostPkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startSession,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqIsRead,
  input  logic [WORD_BITS-1:0] reqWord,
  output logic                 rdValid,
  output logic [READ_BITS-1:0] rdData,
  output logic                 pgClk,
  output logic                 pgDataOut,
  output logic                 pgDataOe,
  input  logic                 pgDataIn
);
  ctrlStrobeT strobe;
  logic       riseTick;
  logic       fallTick;

  progHostCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startSession(startSession),
    .reqValid(reqValid), .reqIsRead(reqIsRead),
    .riseTick(riseTick), .fallTick(fallTick),
    .reqReady(reqReady), .strobe(strobe)
  );

  progHostDatapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWord(reqWord),
    .pgDataIn(pgDataIn), .riseTick(riseTick), .fallTick(fallTick),
    .pgClk(pgClk), .pgDataOut(pgDataOut), .pgDataOe(pgDataOe),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/progHostChk.sv
module progHostChk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic pgClk,
  input logic pgDataOut,
  input logic pgDataOe,
  input logic reqReady,
  input logic rdValid
);
  logic [15:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN)      highRun <= '0;
    else if (pgClk) highRun <= highRun + 1'b1;
    else            highRun <= '0;
  end

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (pgClk && $past(pgClk)) |-> $stable(pgDataOut)); // R3

  AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgClk) |-> (highRun == 16'(HALF_DIV))); // R2

  AST_OE_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pgDataOe) || $rose(pgDataOe)) |-> !pgClk); // R6

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R7

  AST_RDVALID_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($rose(pgClk) && !pgDataOe)); // R7

  AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && pgClk) |=> !pgClk); // R9
endmodule

bind progHostSeq progHostChk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .pgClk(pgClk), .pgDataOut(pgDataOut),
  .pgDataOe(pgDataOe), .reqReady(reqReady), .rdValid(rdValid)
);

// File: tb/test_progHostSeq.sv
`timescale 1ns/1ps
module test_progHostSeq;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startSession = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqIsRead = 1'b0;
  logic [23:0] reqWord = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        pgClk;
  logic        pgDataOut;
  logic        pgDataOe;
  logic        pgDataIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = !clk;

  progHostSeq #(.HALF_DIV(H)) i_progHostSeq (
    .clk(clk), .rstN(rstN), .startSession(startSession),
    .reqValid(reqValid), .reqReady(reqReady), .reqIsRead(reqIsRead),
    .reqWord(reqWord), .rdValid(rdValid), .rdData(rdData),
    .pgClk(pgClk), .pgDataOut(pgDataOut), .pgDataOe(pgDataOe),
    .pgDataIn(pgDataIn)
  );

  // Behavioural reference model
  bit          mRun, mClk, mRead, mFirst, mRdValid;
  int          mDiv, mIdx, mLen, mKind;   // kind 0 short exec, 1 long exec, 2 read
  bit          mBits[33];
  logic [15:0] mRx, mRdData, mTgt;
  logic [15:0] tgtQ[$];
  logic [15:0] expQ[$];

  function automatic bit modelReady();
    return !mRun || (mDiv == H-1 && mClk && mIdx == mLen-1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mClk = 0; mRead = 0; mFirst = 1; mRdValid = 0;
      mDiv = 0; mIdx = 0; mLen = 28; mKind = 0; mRx = '0; mRdData = '0;
      foreach (mBits[i]) mBits[i] = 0;
    end else begin
      bit acc;
      bit nextFirst;
      acc = reqValid && modelReady();
      nextFirst = startSession ? 1'b1 : ((acc && !reqIsRead) ? 1'b0 : mFirst);
      mRdValid = 0;
      if (mRun) begin
        if (mDiv == H-1) begin
          mDiv = 0;
          if (!mClk) begin
            mClk = 1;
            if (mRead && mIdx >= 12) begin
              mRx[mIdx-12] = pgDataIn;
              if (mIdx == 27) begin mRdValid = 1; mRdData = mRx; end
            end
          end else begin
            mClk = 0;
            if (mIdx == mLen-1) mRun = 0; else mIdx++;
          end
        end else mDiv++;
      end
      if (acc) begin
        foreach (mBits[i]) mBits[i] = 0;
        mRun = 1; mDiv = 0; mClk = 0; mIdx = 0; mRead = reqIsRead;
        if (reqIsRead) begin
          mKind = 2; mLen = 28; mBits[0] = 1; mTgt = tgtQ.pop_front();
        end else if (mFirst) begin
          mKind = 1; mLen = 33;
          for (int i = 0; i < 24; i++) mBits[9+i] = reqWord[i];
        end else begin
          mKind = 0; mLen = 28;
          for (int i = 0; i < 24; i++) mBits[4+i] = reqWord[i];
        end
      end
      mFirst = nextFirst;
    end
  end

  // Per-cycle comparison, target drive and pin statistics
  bit prevClk = 0;
  int riseCnt = 0, lowRun = 0, maxLow = 0;

  always @(negedge clk) begin
    if (rstN) begin
      bit ok;
      bit expData, expOe;
      ok = 1;
      expData = mRun ? mBits[mIdx] : 1'b0;
      expOe   = !(mRun && mRead && mIdx >= 12);
      nChecks++;
      if (pgClk !== mClk) begin ok = 0;
        $display("FAIL R2 pgClk=%0b expected %0b", pgClk, mClk); end
      if (pgDataOut !== expData) begin ok = 0;
        $display("FAIL %s pgDataOut=%0b expected %0b (bit %0d)",
          mKind == 1 ? "R5" : (mKind == 2 ? "R6" : "R4"), pgDataOut, expData, mIdx); end
      if (pgDataOe !== expOe) begin ok = 0;
        $display("FAIL R6 pgDataOe=%0b expected %0b", pgDataOe, expOe); end
      if (reqReady !== modelReady()) begin ok = 0;
        $display("FAIL R9 reqReady=%0b expected %0b", reqReady, modelReady()); end
      if (rdValid !== mRdValid) begin ok = 0;
        $display("FAIL R7 rdValid=%0b expected %0b", rdValid, mRdValid); end
      if (mRdValid && rdData !== mRdData) begin ok = 0;
        $display("FAIL R7 rdData=%h expected %h", rdData, mRdData); end
      if (!ok) nFails++;
      if (rdValid) begin
        logic [15:0] e;
        e = (expQ.size() > 0) ? expQ.pop_front() : 16'hxxxx;
        nChecks++;
        if (rdData !== e) begin nFails++;
          $display("FAIL R7 read result=%h expected %h", rdData, e); end
      end
      if (pgClk && !prevClk) begin
        if (riseCnt > 0 && lowRun > maxLow) maxLow = lowRun;
        riseCnt++;
      end
      if (!pgClk) lowRun++; else lowRun = 0;
      prevClk = pgClk;
      pgDataIn = (mRun && mRead && mIdx >= 12) ? mTgt[mIdx-12] : 1'b0;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    nChecks++;
    if (!cond) begin nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic sendReq(input bit rd, input logic [23:0] w, input logic [15:0] t);
    reqValid = 1; reqIsRead = rd; reqWord = w;
    if (rd) begin tgtQ.push_back(t); expQ.push_back(t); end
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitIdle();
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearStats();
    riseCnt = 0; maxLow = 0; lowRun = 0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(pgClk == 0 && pgDataOe == 1 && pgDataOut == 0 && reqReady == 1 && rdValid == 0,
          "R1 idle pins", {pgClk, pgDataOe, pgDataOut, reqReady, rdValid}, 5'b01010);

    // R5 first command after reset is stretched
    clearStats();
    sendReq(0, 24'hA5C3F1, 16'h0);
    waitIdle();
    check(riseCnt == 33, "R5 first exec clocks", riseCnt, 33);

    // R4 normal exec, R9 ready low while busy
    clearStats();
    sendReq(0, 24'h123456, 16'h0);
    repeat (5) @(negedge clk);
    check(reqReady == 0, "R9 ready while busy", reqReady, 0);
    waitIdle();
    check(riseCnt == 28, "R4 exec clocks", riseCnt, 28);
    check(pgDataOe == 1 && pgClk == 0, "R1 idle after frame", {pgDataOe, pgClk}, 2'b10);

    // R6/R7 register read
    clearStats();
    sendReq(1, 24'h0, 16'hBEEF);
    waitIdle();
    check(riseCnt == 28, "R6 read clocks", riseCnt, 28);

    // R10 session restart, R11 read keeps stretch armed
    @(negedge clk); startSession = 1;
    @(negedge clk); startSession = 0;
    clearStats();
    sendReq(1, 24'h0, 16'h1234);
    waitIdle();
    check(riseCnt == 28, "R11 read after session clocks", riseCnt, 28);
    clearStats();
    sendReq(0, 24'h0F0F0F, 16'h0);
    waitIdle();
    check(riseCnt == 33, "R10 R11 stretched exec after session", riseCnt, 33);
    clearStats();
    sendReq(0, 24'hFFFFFF, 16'h0);
    waitIdle();
    check(riseCnt == 28, "R5 later exec not stretched", riseCnt, 28);

    // R8 back-to-back frames
    clearStats();
    sendReq(0, 24'hFFFFFF, 16'h0);
    sendReq(1, 24'h0, 16'h8001);
    sendReq(0, 24'h000001, 16'h0);
    sendReq(1, 24'h0, 16'h7FFE);
    waitIdle();
    check(riseCnt == 112, "R8 back-to-back clocks", riseCnt, 112);
    check(maxLow == H, "R8 no gap between frames", maxLow, H);
    check(expQ.size() == 0, "R7 all reads returned", expQ.size(), 0);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule